// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer and Memory/I-O Decoder

This block connects an 8-bit processor whose low address byte shares pins with its data bus to an EPROM, a static RAM and a pair of I/O buffers. When the address strobe falls, it captures the shared low byte and the dedicated high byte and keeps the rebuilt 16-bit address stable until the next strobe. It also slices out the address lines that each memory needs.

From the captured address and read/write flag, the block selects at most one target. It drives the data transceiver's direction, and it drives the transceiver's output enable from a data-phase enable that lags the strobe edge by one clock. As a result the transceiver stays high-impedance while the address is on the shared pins. All selects and enables are registered, active-low and synchronous to the system clock. They go inactive on the first clock edge that sees the strobe high.

The address map is fixed by parameters. EPROM occupies 0x8000-0xFFFF and is read-only. RAM occupies 0x0000-0x1FFF. I/O occupies 0x4000-0x40FF. Any other address selects nothing.

Top module: `muxbus_decoder`

## Requirements
- R1: A synchronous active-low reset sets every active-low select/enable output to 1, the latched address to 0x0000 and the transceiver direction to 0.
- R2: On the first clock edge where the strobe is sampled low after being sampled high, the latched address becomes {high byte, shared low byte}. It then holds, whatever the inputs do, until the next such falling edge.
- R3: On that same edge, the transceiver direction output takes the read/write input (1 = read, data flows toward the processor). This happens one edge before any enable asserts.
- R4: No select, enable or transceiver output enable is active after the edge that latches the address. They may first assert after the following edge, which is the delayed data phase.
- R5: Every clock edge that samples the strobe high leaves all selects and enables inactive.
- R6: A read in 0x8000-0xFFFF drives the EPROM select low, and the EPROM address output equals latched address bits [14:0]. A write in that range asserts no select and leaves the transceiver disabled.
- R7: A read in 0x0000-0x1FFF drives the RAM select and RAM output enable low and keeps RAM write enable high. The RAM address output equals latched address bits [12:0].
- R8: A write in 0x0000-0x1FFF drives the RAM select, RAM output enable and RAM write enable all low.
- R9: In 0x4000-0x40FF, a read drives the input-buffer enable low with the output-buffer enable high, and a write does the reverse. The two are never low together.
- R10: An access to any other address (e.g. 0x2000, 0x3FFF, 0x4100, 0x7FFF) asserts no select and leaves the transceiver disabled.
- R11: At most one of EPROM select, RAM select, I/O input enable and I/O output enable is low at any time.
- R12: The transceiver output enable is low exactly when one of the target selects/enables of R11 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| as_i | input | 1 | Address strobe, high during address phase |
| rnw_i | input | 1 | 1 = read, 0 = write |
| ad_i | input | 8 | Shared low address / data byte as seen by the block |
| addr_hi_i | input | 8 | Dedicated high address byte |
| addr_o | output | 16 | Rebuilt, latched address |
| rom_addr_o | output | 15 | EPROM address lines |
| ram_addr_o | output | 13 | RAM address lines |
| xcvr_dir_o | output | 1 | Transceiver direction, 1 = toward processor |
| xcvr_oe_n_o | output | 1 | Transceiver output enable, active low |
| rom_cs_n_o | output | 1 | EPROM select, active low |
| ram_cs_n_o | output | 1 | RAM select, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| io_in_en_n_o | output | 1 | I/O input buffer enable, active low |
| io_out_en_n_o | output | 1 | I/O output buffer enable, active low |

## Verification
The bench probes both edges of every region. It uses 0x1FFF against 0x2000, 0x3FFF against 0x4000, 0x40FF against 0x4100, and 0x7FFF against 0x8000. A comparator that is one bit too wide or too narrow shows up there as a stray or missing select. It checks outputs on the cycle right after the strobe falls, which catches a design that enables the transceiver during the address phase. It also flips the shared and high bytes during the data phase, which exposes a transparent rather than edge-captured latch. Further cases cover EPROM writes, RAM writes (a design that left output enable high there is caught), and a reset issued mid-access (a design that left a select asserted is caught).

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    // Access target chosen by the region decoder.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2,
        TGT_IO   = 2'd3
    } tgt_e;

    // Registered active-low control outputs.
    typedef struct packed {
        logic rom_cs_n;
        logic ram_cs_n;
        logic ram_oe_n;
        logic ram_we_n;
        logic io_in_n;
        logic io_out_n;
        logic xcvr_oe_n;
    } strobe_t;

    localparam strobe_t STROBE_IDLE = '{
        rom_cs_n:  1'b1,
        ram_cs_n:  1'b1,
        ram_oe_n:  1'b1,
        ram_we_n:  1'b1,
        io_in_n:   1'b1,
        io_out_n:  1'b1,
        xcvr_oe_n: 1'b1
    };

endpackage

// File: rtl/muxbus_addr_latch.sv
module muxbus_addr_latch #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     as_i,
    input  logic                     rnw_i,
    input  logic [DATA_W-1:0]        ad_i,
    input  logic [ADDR_W-DATA_W-1:0] hi_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic                     rnw_o,
    output logic                     dphase_d_o
);

    typedef struct packed {
        logic              as_prev;
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic              valid;
        logic              dphase;
    } lat_t;

    lat_t st_d, st_q;
    logic as_fall;

    always_comb begin
        st_d         = st_q;
        st_d.as_prev = as_i;
        as_fall      = st_q.as_prev & ~as_i;
        if (as_i) begin
            st_d.valid  = 1'b0;
            st_d.dphase = 1'b0;
        end else if (as_fall) begin
            st_d.addr   = {hi_i, ad_i};
            st_d.rnw    = rnw_i;
            st_d.valid  = 1'b1;
            st_d.dphase = 1'b0;
        end else begin
            st_d.dphase = st_q.valid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o     = st_q.addr;
    assign rnw_o      = st_q.rnw;
    assign dphase_d_o = st_d.dphase;

    // R2: capture on the strobe falling edge
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.as_prev && !as_i) |=> (addr_o == $past({hi_i, ad_i})));

    // R2: hold between falling edges
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.as_prev && !as_i) |=> $stable(addr_o));

    // R3: direction taken on the same edge as the address
    a_r3_dir_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.as_prev && !as_i) |=> (rnw_o == $past(rnw_i)));

    // R3: direction steady while no new strobe arrives
    a_r3_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.as_prev && !as_i) |=> $stable(rnw_o));

endmodule

// File: rtl/muxbus_region_decode.sv
module muxbus_region_decode
    import muxbus_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter int                 ROM_AW   = 15,
    parameter int                 RAM_AW   = 13,
    parameter int                 IO_AW    = 8,
    parameter logic [ADDR_W-1:0]  ROM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0]  RAM_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0]  IO_BASE  = 16'h4000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o
);

    localparam int NREG = 3;
    localparam int REG_ROM = 0;
    localparam int REG_RAM = 1;
    localparam int REG_IO  = 2;
    localparam logic [ADDR_W-1:0] BASES [NREG] = '{ROM_BASE, RAM_BASE, IO_BASE};
    localparam int                SPANS [NREG] = '{ROM_AW, RAM_AW, IO_AW};

    logic [NREG-1:0] hit;

    // One comparator per region: upper bits above the region's span must match.
    for (genvar g = 0; g < NREG; g++) begin : g_region
        assign hit[g] = ((addr_i >> SPANS[g]) == (BASES[g] >> SPANS[g]));
    end

    // Fixed priority ROM > RAM > IO; regions never overlap with the defaults.
    always_comb begin
        if (hit[REG_ROM]) begin
            tgt_o = TGT_ROM;
        end else if (hit[REG_RAM]) begin
            tgt_o = TGT_RAM;
        end else if (hit[REG_IO]) begin
            tgt_o = TGT_IO;
        end else begin
            tgt_o = TGT_NONE;
        end
    end

endmodule

// File: rtl/muxbus_strobe_gen.sv
module muxbus_strobe_gen
    import muxbus_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    as_i,
    input  logic    dphase_i,
    input  logic    rnw_i,
    input  tgt_e    tgt_i,
    output strobe_t str_o
);

    strobe_t str_d, str_q;

    always_comb begin
        str_d = STROBE_IDLE;
        if (dphase_i) begin
            unique case (tgt_i)
                TGT_ROM: begin
                    if (rnw_i) begin
                        str_d.rom_cs_n  = 1'b0;
                        str_d.xcvr_oe_n = 1'b0;
                    end
                end
                TGT_RAM: begin
                    str_d.ram_cs_n  = 1'b0;
                    str_d.ram_oe_n  = 1'b0;
                    str_d.ram_we_n  = rnw_i;
                    str_d.xcvr_oe_n = 1'b0;
                end
                TGT_IO: begin
                    str_d.io_in_n   = ~rnw_i;
                    str_d.io_out_n  = rnw_i;
                    str_d.xcvr_oe_n = 1'b0;
                end
                default: begin
                    str_d = STROBE_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            str_q <= STROBE_IDLE;
        end else begin
            str_q <= str_d;
        end
    end

    assign str_o = str_q;

    // R5: strobe high clears every enable on the next edge
    a_r5_as_clears: assert property (@(posedge clk) disable iff (!rst_n)
        as_i |=> (str_q == STROBE_IDLE));

    // R4: nothing asserted right after the latching edge
    a_r4_delayed_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_i) |=> (str_q == STROBE_IDLE));

    // R8: a RAM write also holds output enable and select low
    a_r8_write_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
        !str_q.ram_we_n |-> (!str_q.ram_oe_n && !str_q.ram_cs_n));

    // R9: I/O buffers never both on
    a_r9_io_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!str_q.io_in_n && !str_q.io_out_n));

    // R11: single target
    a_r11_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~str_q.rom_cs_n, ~str_q.ram_cs_n,
                    ~str_q.io_in_n, ~str_q.io_out_n}) <= 1);

    // R12: transceiver enabled exactly with a target
    a_r12_xcvr_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (!str_q.xcvr_oe_n) == (!str_q.rom_cs_n || !str_q.ram_cs_n ||
                               !str_q.io_in_n || !str_q.io_out_n));

endmodule

// File: rtl/muxbus_decoder.sv
module muxbus_decoder
    import muxbus_pkg::*;
#(
    parameter int                 ADDR_W   = 16,
    parameter int                 DATA_W   = 8,
    parameter int                 ROM_AW   = 15,
    parameter int                 RAM_AW   = 13,
    parameter int                 IO_AW    = 8,
    parameter logic [ADDR_W-1:0]  ROM_BASE = 16'h8000,
    parameter logic [ADDR_W-1:0]  RAM_BASE = 16'h0000,
    parameter logic [ADDR_W-1:0]  IO_BASE  = 16'h4000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     as_i,
    input  logic                     rnw_i,
    input  logic [DATA_W-1:0]        ad_i,
    input  logic [ADDR_W-DATA_W-1:0] addr_hi_i,
    output logic [ADDR_W-1:0]        addr_o,
    output logic [ROM_AW-1:0]        rom_addr_o,
    output logic [RAM_AW-1:0]        ram_addr_o,
    output logic                     xcvr_dir_o,
    output logic                     xcvr_oe_n_o,
    output logic                     rom_cs_n_o,
    output logic                     ram_cs_n_o,
    output logic                     ram_oe_n_o,
    output logic                     ram_we_n_o,
    output logic                     io_in_en_n_o,
    output logic                     io_out_en_n_o
);

    logic [ADDR_W-1:0] lat_addr;
    logic              lat_rnw;
    logic              dphase_d;
    tgt_e              tgt;
    strobe_t           str;

    muxbus_addr_latch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .as_i       (as_i),
        .rnw_i      (rnw_i),
        .ad_i       (ad_i),
        .hi_i       (addr_hi_i),
        .addr_o     (lat_addr),
        .rnw_o      (lat_rnw),
        .dphase_d_o (dphase_d)
    );

    muxbus_region_decode #(
        .ADDR_W   (ADDR_W),
        .ROM_AW   (ROM_AW),
        .RAM_AW   (RAM_AW),
        .IO_AW    (IO_AW),
        .ROM_BASE (ROM_BASE),
        .RAM_BASE (RAM_BASE),
        .IO_BASE  (IO_BASE)
    ) u_decode (
        .addr_i (lat_addr),
        .tgt_o  (tgt)
    );

    muxbus_strobe_gen u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .as_i     (as_i),
        .dphase_i (dphase_d),
        .rnw_i    (lat_rnw),
        .tgt_i    (tgt),
        .str_o    (str)
    );

    assign addr_o        = lat_addr;
    assign rom_addr_o    = lat_addr[ROM_AW-1:0];
    assign ram_addr_o    = lat_addr[RAM_AW-1:0];
    assign xcvr_dir_o    = lat_rnw;
    assign xcvr_oe_n_o   = str.xcvr_oe_n;
    assign rom_cs_n_o    = str.rom_cs_n;
    assign ram_cs_n_o    = str.ram_cs_n;
    assign ram_oe_n_o    = str.ram_oe_n;
    assign ram_we_n_o    = str.ram_we_n;
    assign io_in_en_n_o  = str.io_in_n;
    assign io_out_en_n_o = str.io_out_n;

endmodule

// File: tb/muxbus_decoder_tb.sv
module muxbus_decoder_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        as_i = 1'b1;
    logic        rnw_i = 1'b1;
    logic [7:0]  ad_i = 8'h00;
    logic [7:0]  addr_hi_i = 8'h00;
    logic [15:0] addr_o;
    logic [14:0] rom_addr_o;
    logic [12:0] ram_addr_o;
    logic        xcvr_dir_o, xcvr_oe_n_o, rom_cs_n_o, ram_cs_n_o;
    logic        ram_oe_n_o, ram_we_n_o, io_in_en_n_o, io_out_en_n_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    muxbus_decoder u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .as_i          (as_i),
        .rnw_i         (rnw_i),
        .ad_i          (ad_i),
        .addr_hi_i     (addr_hi_i),
        .addr_o        (addr_o),
        .rom_addr_o    (rom_addr_o),
        .ram_addr_o    (ram_addr_o),
        .xcvr_dir_o    (xcvr_dir_o),
        .xcvr_oe_n_o   (xcvr_oe_n_o),
        .rom_cs_n_o    (rom_cs_n_o),
        .ram_cs_n_o    (ram_cs_n_o),
        .ram_oe_n_o    (ram_oe_n_o),
        .ram_we_n_o    (ram_we_n_o),
        .io_in_en_n_o  (io_in_en_n_o),
        .io_out_en_n_o (io_out_en_n_o)
    );

    // {rom_cs_n, ram_cs_n, ram_oe_n, ram_we_n, io_in_n, io_out_n, xcvr_oe_n}
    localparam logic [6:0] IDLE = 7'b1111111;

    // Vector: {address, rnw, expected strobes}
    localparam int NV = 12;
    localparam logic [23:0] VEC [NV] = '{
        {16'h8000, 1'b1, 7'b0111110},
        {16'hFFFF, 1'b1, 7'b0111110},
        {16'h9ABC, 1'b0, 7'b1111111},
        {16'h0000, 1'b1, 7'b1001110},
        {16'h1FFF, 1'b0, 7'b1000110},
        {16'h2000, 1'b1, 7'b1111111},
        {16'h4000, 1'b1, 7'b1111010},
        {16'h40FF, 1'b0, 7'b1111100},
        {16'h4100, 1'b1, 7'b1111111},
        {16'h7FFF, 1'b0, 7'b1111111},
        {16'h1234, 1'b1, 7'b1001110},
        {16'h3FFF, 1'b0, 7'b1111111}
    };

    function automatic logic [6:0] obs();
        return {rom_cs_n_o, ram_cs_n_o, ram_oe_n_o, ram_we_n_o,
                io_in_en_n_o, io_out_en_n_o, xcvr_oe_n_o};
    endfunction

    function automatic string region_tag(logic [15:0] a, logic rd);
        if (a >= 16'h8000) return "R6";
        if (a <= 16'h1FFF) return rd ? "R7" : "R8";
        if (a >= 16'h4000 && a <= 16'h40FF) return "R9";
        return "R10";
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // One full bus cycle; checks every phase.
    task automatic access(logic [15:0] a, logic rd, logic [6:0] exp);
        string tag;
        logic  any_sel;
        tag = region_tag(a, rd);
        @(negedge clk);
        as_i = 1'b1; ad_i = a[7:0]; addr_hi_i = a[15:8]; rnw_i = rd;
        @(negedge clk);
        as_i = 1'b0;
        @(negedge clk);                       // latching edge done
        chk("R4 idle after latch edge", obs(), IDLE);
        chk("R2 address captured", addr_o, a);
        chk("R3 direction", xcvr_dir_o, rd);
        ad_i = ~a[7:0]; addr_hi_i = ~a[15:8]; rnw_i = ~rd;
        @(negedge clk);                       // data phase active
        chk(tag, obs(), exp);
        chk("R2 address held in data phase", addr_o, a);
        chk("R3 direction held", xcvr_dir_o, rd);
        any_sel = !rom_cs_n_o || !ram_cs_n_o || !io_in_en_n_o || !io_out_en_n_o;
        chk("R12 transceiver vs selects", !xcvr_oe_n_o, any_sel);
        if (tag == "R6") chk("R6 rom address", rom_addr_o, a[14:0]);
        if (tag == "R7" || tag == "R8") chk("R7 ram address", ram_addr_o, a[12:0]);
        @(negedge clk);
        chk({tag, " steady"}, obs(), exp);
        as_i = 1'b1;
        @(negedge clk);
        chk("R5 cleared by strobe high", obs(), IDLE);
        chk("R2 address held after cycle", addr_o, a);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 enables in reset", obs(), IDLE);
        chk("R1 address in reset", addr_o, 16'h0000);
        chk("R1 direction in reset", xcvr_dir_o, 1'b0);
        rst_n = 1'b1;

        // R5: long address phase with moving inputs never enables anything
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ad_i = 8'(k); addr_hi_i = 8'h80; rnw_i = 1'b1;
            @(negedge clk);
            chk("R5 strobe high no enable", obs(), IDLE);
            chk("R2 no capture without fall", addr_o, 16'h0000);
        end

        // Table walk: R6..R12 per region
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][23:8], VEC[i][7], VEC[i][6:0]);
        end

        // Back-to-back: RAM write then ROM read; address must update (R2)
        access(16'h0ABC, 1'b0, 7'b1000110);
        access(16'hC001, 1'b1, 7'b0111110);
        chk("R6 rom address slice", rom_addr_o, 15'h4001);

        // R1: reset during a data phase
        @(negedge clk);
        as_i = 1'b1; ad_i = 8'h55; addr_hi_i = 8'h01; rnw_i = 1'b0;
        @(negedge clk);
        as_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R8 write before reset", obs(), 7'b1000110);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid access clears enables", obs(), IDLE);
        chk("R1 reset mid access clears address", addr_o, 16'h0000);
        chk("R1 reset mid access clears direction", xcvr_dir_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R4 no restart after reset release", obs(), IDLE);
        as_i = 1'b1;
        @(negedge clk);

        // R11: I/O read after I/O write switches buffers cleanly
        access(16'h4080, 1'b0, 7'b1111100);
        access(16'h4080, 1'b1, 7'b1111010);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule